// File: doc/BRIEF.md
# Segment Address Translation and Protection Unit

This unit maps a 32-bit logical address onto a 36-bit physical address through a bank of sixteen programmable segment descriptors. It also decides whether the requested access is allowed. Each descriptor is held as two 32-bit words and is written through a one-word-per-cycle configuration port. The high word carries the logical base and a size code. The low word carries the physical replacement base and six grant bits.

A segment always spans a power-of-two number of bytes. Only the logical address bits above the segment's size take part in matching a descriptor. Those same bit positions are the ones replaced by the physical base; the offset bits below them pass through unchanged. When several descriptors match, the one with the largest index is used.

Each lookup presents an address, an access kind and a privilege level. The translated address, a hit flag and a permission-fault flag appear one clock later from a single output register stage.

Top module: `sxu_top`

## Requirements
- R1: After reset, descriptor 0 maps logical 0x0000_0000..0x7FFF_FFFF one-to-one onto physical 0x0_0000_0000, and descriptor 1 maps logical 0x8000_0000..0xFFFF_FFFF onto physical 0x8_0000_0000. Both grant every access. Descriptors 2..15 are all-zero.
- R2: A configuration write with `cfg_we`=1 stores `cfg_wdata` into descriptor `cfg_idx`. The high word is selected with `cfg_hi`=1 and the low word with `cfg_hi`=0. A lookup captured at the same clock edge still sees the old contents. The next edge sees the new contents.
- R3: High-word bits 4:0 hold a size code c, and the segment spans 2^(c+1) bytes. High-word bits 31:12 are logical base bits 31:12. Logical address bits 31..c+1 are compared with the base, and code 31 matches every address.
- R4: A descriptor whose size code is below 11 never matches.
- R5: When several descriptors match, the highest-indexed one supplies the result.
- R6: Low-word bits 31:8 hold physical bits 35:12. The output address takes physical bits 35..c+1 from that base and bits c..0 from the logical address.
- R7: Low-word bits 5:0 grant supervisor read, write, execute in bits 5,4,3 and user read, write, execute in bits 2,1,0. `lk_kind` encodes 0 = read, 1 = write, 2 = execute; code 3 is never granted.
- R8: `out_fault` is 1 only when a descriptor matched and its grant bit for the requested kind and privilege is clear. The translated address is still reported in that case.
- R9: When no descriptor matches, `out_hit`=0, `out_fault`=0 and `out_paddr`=0.
- R10: The outputs are registered and reflect the lookup inputs of the previous clock edge. During reset they are all zero.
- R11: High-word bits 11:5 and low-word bits 7:6 have no effect on matching, translation or grants.
- R12: Logical-base bits that lie below the segment size have no effect on matching or translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor word write strobe |
| cfg_idx | input | 4 | Descriptor index to write |
| cfg_hi | input | 1 | 1 selects the high word, 0 the low word |
| cfg_wdata | input | 32 | Word to store |
| lk_addr | input | 32 | Logical address to translate |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 none |
| lk_super | input | 1 | 1 for supervisor, 0 for user |
| out_paddr | output | 36 | Translated physical address, zero on miss |
| out_hit | output | 1 | A descriptor matched |
| out_fault | output | 1 | Matched descriptor denies the access |

## Verification
The hardest situation to reach is one where overlapping descriptors of different sizes all match the same address. In that case the highest-index winner must hold even though a larger, lower-index segment also covers it. The opposite case matters too: an address one byte beyond the small segment must fall back to the larger one.

The stimulus programs a 4 KiB descriptor at index 15 inside a 1 MiB descriptor at index 2, which in turn lies inside the 2 GiB reset descriptor. It then walks addresses on either side of each boundary. A descriptor that is disabled by its size code, and one whose base and reserved bits hold junk, are placed over the same space. This shows that those bits neither add nor remove matches.

// File: rtl/sxu_pkg.sv
package sxu_pkg;
  localparam int SXU_ENTRIES = 16;
  localparam int LA_W        = 32;
  localparam int PA_W        = 36;
  localparam int PAGE_LSB    = 12;
  localparam int CODE_W      = 5;
  localparam int PERM_W      = 6;
  localparam int MIN_CODE    = 11;
  localparam int IDX_W       = $clog2(SXU_ENTRIES);
  localparam int LBASE_W     = LA_W - PAGE_LSB;
  localparam int RBASE_W     = PA_W - PAGE_LSB;
  localparam int RBASE_LSB   = 8;
  localparam int EXT_W       = PA_W - LA_W;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_NONE  = 2'd3
  } acc_t;

  typedef struct packed {
    logic [LBASE_W-1:0] lbase;
    logic [CODE_W-1:0]  code;
    logic [RBASE_W-1:0] rbase;
    logic [PERM_W-1:0]  perm;
  } seg_t;

  function automatic seg_t seg_decode(input logic [31:0] hi, input logic [31:0] lo);
    seg_t s;
    s.lbase = hi[31:PAGE_LSB];
    s.code  = hi[CODE_W-1:0];
    s.rbase = lo[31:RBASE_LSB];
    s.perm  = lo[PERM_W-1:0];
    return s;
  endfunction

  function automatic logic seg_enabled(input logic [CODE_W-1:0] code);
    return int'(code) >= MIN_CODE;
  endfunction

  // ones on every logical bit that takes part in the match
  function automatic logic [LA_W-1:0] seg_cmp_mask(input logic [CODE_W-1:0] code);
    logic [63:0] span;
    logic [63:0] m;
    span = 64'd1 << (int'(code) + 1);
    m    = ~(span - 64'd1);
    return m[LA_W-1:0];
  endfunction

  function automatic logic seg_hit(input logic [LA_W-1:0] addr, input seg_t s);
    logic [LA_W-1:0] base;
    base = {s.lbase, {PAGE_LSB{1'b0}}};
    return seg_enabled(s.code) && (((addr ^ base) & seg_cmp_mask(s.code)) == '0);
  endfunction

  function automatic logic [PA_W-1:0] seg_compose(input logic [LA_W-1:0] addr, input seg_t s);
    logic [PA_W-1:0] keep;
    logic [PA_W-1:0] base;
    keep = {{EXT_W{1'b1}}, seg_cmp_mask(s.code)};
    base = {s.rbase, {PAGE_LSB{1'b0}}};
    return (base & keep) | ({{EXT_W{1'b0}}, addr} & ~keep);
  endfunction

  function automatic logic seg_perm_ok(input logic [PERM_W-1:0] perm, input acc_t acc,
                                       input logic sup);
    int b;
    if (acc == ACC_NONE) return 1'b0;
    b = (sup ? 3 : 0) + 2 - int'(acc);
    return perm[b];
  endfunction

  function automatic logic [31:0] seg_rst_hi(input int idx);
    if (idx == 0) return 32'h0000_001E;
    if (idx == 1) return 32'h8000_001E;
    return 32'h0;
  endfunction

  function automatic logic [31:0] seg_rst_lo(input int idx);
    if (idx == 0) return 32'h0000_003F;
    if (idx == 1) return 32'h8000_003F;
    return 32'h0;
  endfunction
endpackage

// File: rtl/sxu_entry_bank.sv
module sxu_entry_bank
  import sxu_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic                          wr_hi,
  input  logic [31:0]                   wr_data,
  output seg_t [SXU_ENTRIES-1:0]        seg_o
);
  logic [SXU_ENTRIES-1:0][31:0] hi_q;
  logic [SXU_ENTRIES-1:0][31:0] lo_q;

  for (genvar gi = 0; gi < SXU_ENTRIES; gi++) begin : g_ent
    logic sel_w;
    assign sel_w = wr_en && (wr_idx == IDX_W'(gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q[gi] <= seg_rst_hi(gi);
        lo_q[gi] <= seg_rst_lo(gi);
      end else if (sel_w) begin
        if (wr_hi) hi_q[gi] <= wr_data;
        else       lo_q[gi] <= wr_data;
      end
    end

    assign seg_o[gi] = seg_decode(hi_q[gi], lo_q[gi]);

    // R2: a write lands in the addressed word at the next edge
    a_r2_hi_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_hi && wr_idx == IDX_W'(gi)) |=> hi_q[gi] == $past(wr_data));
    a_r2_lo_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_hi && wr_idx == IDX_W'(gi)) |=> lo_q[gi] == $past(wr_data));
    a_r2_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_idx == IDX_W'(gi)) |=> $stable(hi_q[gi]) && $stable(lo_q[gi]));
  end
endmodule

// File: rtl/sxu_match_array.sv
module sxu_match_array
  import sxu_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LA_W-1:0]        addr,
  input  seg_t [SXU_ENTRIES-1:0] seg_i,
  output logic [SXU_ENTRIES-1:0] hit_vec
);
  for (genvar gi = 0; gi < SXU_ENTRIES; gi++) begin : g_cmp
    assign hit_vec[gi] = seg_hit(addr, seg_i[gi]);

    // R4: an entry with a too-small size code stays silent
    a_r4_small_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(seg_i[gi].code) < MIN_CODE) |-> !hit_vec[gi]);
  end
endmodule

// File: rtl/sxu_prio_sel.sv
module sxu_prio_sel
  import sxu_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SXU_ENTRIES-1:0] hit_vec,
  output logic [IDX_W-1:0]       win_idx,
  output logic [SXU_ENTRIES-1:0] win_oh,
  output logic                   any_hit
);
  always_comb begin
    win_idx = '0;
    for (int i = 0; i < SXU_ENTRIES; i++) begin
      if (hit_vec[i]) win_idx = IDX_W'(i);
    end
  end

  assign any_hit = |hit_vec;
  assign win_oh  = any_hit ? (SXU_ENTRIES'(1) << win_idx) : '0;

  // R5: at most one winner, and no matching entry above it
  a_r5_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh));
  a_r5_top_wins: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> ((hit_vec >> win_idx) == SXU_ENTRIES'(1)));
endmodule

// File: rtl/sxu_top.sv
module sxu_top
  import sxu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_idx,
  input  logic             cfg_hi,
  input  logic [31:0]      cfg_wdata,
  input  logic [31:0]      lk_addr,
  input  logic [1:0]       lk_kind,
  input  logic             lk_super,
  output logic [35:0]      out_paddr,
  output logic             out_hit,
  output logic             out_fault
);
  seg_t [SXU_ENTRIES-1:0] seg_all;
  logic [SXU_ENTRIES-1:0] hit_vec;
  logic [SXU_ENTRIES-1:0] win_oh;
  logic [IDX_W-1:0]       win_idx;
  logic                   any_hit;
  seg_t                   win_seg;
  logic                   grant_w;
  logic [PA_W-1:0]        paddr_c;
  logic                   fault_c;

  sxu_entry_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_idx),
    .wr_hi   (cfg_hi),
    .wr_data (cfg_wdata),
    .seg_o   (seg_all)
  );

  sxu_match_array u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (lk_addr),
    .seg_i   (seg_all),
    .hit_vec (hit_vec)
  );

  sxu_prio_sel u_prio (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_vec (hit_vec),
    .win_idx (win_idx),
    .win_oh  (win_oh),
    .any_hit (any_hit)
  );

  assign win_seg = seg_all[win_idx];
  assign grant_w = seg_perm_ok(win_seg.perm, acc_t'(lk_kind), lk_super);
  assign paddr_c = any_hit ? seg_compose(lk_addr, win_seg) : '0;
  assign fault_c = any_hit && !grant_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_paddr <= '0;
      out_hit   <= 1'b0;
      out_fault <= 1'b0;
    end else begin
      out_paddr <= paddr_c;
      out_hit   <= any_hit;
      out_fault <= fault_c;
    end
  end

  // R9: a miss reports zero address and no fault
  a_r9_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
    !out_hit |-> (out_paddr == '0) && !out_fault);
  // R8: a fault only accompanies a hit
  a_r8_fault_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> out_hit);
  // R6: the page offset always passes through from the previous lookup
  a_r6_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |=> out_paddr[PAGE_LSB-1:0] == $past(lk_addr[PAGE_LSB-1:0]));
  // R10: the hit flag follows the lookup one edge later
  a_r10_one_stage: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_hit == $past(|hit_vec));
  // R7: access kind 3 is never granted
  a_r7_none_denied: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_kind == 2'd3 && |win_oh) |=> out_fault);
endmodule

// File: tb/sxu_top_tb_top.sv
module sxu_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic        cfg_hi = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] lk_addr = '0;
  logic [1:0]  lk_kind = '0;
  logic        lk_super = 1'b0;
  logic [35:0] out_paddr;
  logic        out_hit;
  logic        out_fault;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  sxu_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_hi(cfg_hi),
    .cfg_wdata(cfg_wdata), .lk_addr(lk_addr), .lk_kind(lk_kind), .lk_super(lk_super),
    .out_paddr(out_paddr), .out_hit(out_hit), .out_fault(out_fault)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  kind;
    logic        sup;
    logic        hit;
    logic        fault;
    logic [35:0] paddr;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{32'h5001_2345, 2'd0, 1'b0, 1'b1, 1'b0, 36'h0_0C01_2345},
    '{32'h5001_2345, 2'd2, 1'b0, 1'b1, 1'b1, 36'h0_0C01_2345},
    '{32'h5000_0ABC, 2'd0, 1'b1, 1'b1, 1'b0, 36'hF_FFFF_FABC},
    '{32'h5000_0ABC, 2'd1, 1'b0, 1'b1, 1'b1, 36'hF_FFFF_FABC},
    '{32'h5000_1ABC, 2'd1, 1'b1, 1'b1, 1'b0, 36'h0_0C00_1ABC},
    '{32'h6000_0010, 2'd0, 1'b0, 1'b1, 1'b0, 36'h0_6000_0010},
    '{32'hA0AB_CDEF, 2'd2, 1'b1, 1'b1, 1'b0, 36'h3_12AB_CDEF},
    '{32'hA0AB_CDEF, 2'd0, 1'b0, 1'b1, 1'b1, 36'h3_12AB_CDEF},
    '{32'hA0AB_CDEF, 2'd3, 1'b1, 1'b1, 1'b1, 36'h3_12AB_CDEF},
    '{32'h9000_0000, 2'd1, 1'b0, 1'b1, 1'b0, 36'h8_1000_0000},
    '{32'h500F_FFFF, 2'd0, 1'b0, 1'b1, 1'b0, 36'h0_0C0F_FFFF},
    '{32'h5010_0000, 2'd0, 1'b0, 1'b1, 1'b0, 36'h0_5010_0000},
    '{32'hA100_0000, 2'd2, 1'b1, 1'b1, 1'b0, 36'h8_2100_0000}
  };
  // requirement each row exercises
  localparam string VREQ [NV] = '{"R3/R6", "R7/R8", "R5", "R5/R7", "R5", "R4", "R11/R12",
                                  "R7/R8", "R7", "R1", "R3", "R3", "R12"};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic hi, input logic [31:0] data);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_hi = hi; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic look(input logic [31:0] a, input logic [1:0] k, input logic s);
    lk_addr = a; lk_kind = k; lk_super = s;
    @(negedge clk);
  endtask

  task automatic expect3(input string req, input logic h, input logic f, input logic [35:0] p);
    check({req, " hit"}, 64'(out_hit), 64'(h));
    check({req, " fault"}, 64'(out_fault), 64'(f));
    check({req, " paddr"}, 64'(out_paddr), 64'(p));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    lk_addr = 32'h1234_5678; lk_kind = 2'd1;
    repeat (3) @(negedge clk);
    // R10: outputs held at zero in reset
    expect3("R10 reset", 1'b0, 1'b0, 36'h0);
    rst_n = 1'b1;
    // R1: reset mappings
    look(32'h1234_5678, 2'd1, 1'b0);
    expect3("R1 entry0", 1'b1, 1'b0, 36'h0_1234_5678);
    look(32'hFFFF_FFFF, 2'd2, 1'b0);
    expect3("R1 entry1", 1'b1, 1'b0, 36'h8_7FFF_FFFF);

    // program overlapping descriptors
    wr(2,  1'b1, 32'h5000_0013); wr(2,  1'b0, 32'h00C0_0036);
    wr(3,  1'b1, 32'h6000_000A); wr(3,  1'b0, 32'h0000_003F);
    wr(4,  1'b1, 32'hA00F_F7F7); wr(4,  1'b0, 32'h3120_00F8);
    wr(15, 1'b1, 32'h5000_000B); wr(15, 1'b0, 32'hFFFF_FF24);

    for (int i = 0; i < NV; i++) begin
      look(VECS[i].addr, VECS[i].kind, VECS[i].sup);
      expect3(VREQ[i], VECS[i].hit, VECS[i].fault, VECS[i].paddr);
    end

    // R2: write and lookup at the same edge see old contents, next edge sees new
    wr(6, 1'b0, 32'h2000_003F);
    lk_addr = 32'h7000_0042; lk_kind = 2'd0; lk_super = 1'b0;
    cfg_we = 1'b1; cfg_idx = 4'd6; cfg_hi = 1'b1; cfg_wdata = 32'h7000_0013;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R2 old contents", 64'(out_paddr), 64'h0_7000_0042);
    @(negedge clk);
    check("R2 new contents", 64'(out_paddr), 64'h2_0000_0042);

    // R3: code 31 covers the whole space
    wr(14, 1'b0, 32'h4000_003F); wr(14, 1'b1, 32'h0000_001F);
    look(32'h1234_5678, 2'd0, 1'b0);
    expect3("R3 full span", 1'b1, 1'b0, 36'h4_1234_5678);
    look(32'h5000_0ABC, 2'd0, 1'b0);
    check("R5 above full span", 64'(out_paddr), 64'hF_FFFF_FABC);

    // R9: clear the catch-all descriptors and miss
    wr(14, 1'b1, 32'h0); wr(0, 1'b1, 32'h0); wr(1, 1'b1, 32'h0);
    look(32'h1234_5678, 2'd3, 1'b1);
    expect3("R9 miss", 1'b0, 1'b0, 36'h0);
    look(32'h5001_0000, 2'd0, 1'b0);
    expect3("R9 still hits entry2", 1'b1, 1'b0, 36'h0_0C01_0000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule